// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block merges the five interrupt causes of a UART into one prioritised four-bit cause code and a single interrupt line. The causes are a receiver error or break, received data at the trigger level, a receiver idle timeout, an empty transmit holding stage, and a change on the modem inputs. Mode bits for FIFO operation and the deep-FIFO mode are placed above the code to form an 8-bit identification value. The register file reads this value and drives the enable bits and the read and write strobes.

Three causes arrive as one-cycle events and are held by a two-state machine per cause, with states CLEAR and PENDING. The transition CLEAR to PENDING is taken on the event. The transition PENDING to CLEAR is taken on that cause's acknowledging read, unless a new event arrives in the same cycle. The transmit-empty cause has its own two-state machine with the same state names. CLEAR to PENDING is taken when the transmit stage becomes empty, or when its enable rises while the stage is already empty. PENDING to CLEAR is taken on a write to the holding stage, or on a read of the identification value while that value reports transmit-empty. Received data at the trigger level is a level from the receive FIFO and is used directly.

A combinational arbiter picks the highest enabled pending cause. Clearing an enable bit removes its cause from arbitration at once. The held state is kept, so the cause shows again when the enable is set back.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset no cause is pending: ident[3:0] is 4'b0001 and irq is 0.
- R2: Priority from highest to lowest, with codes in ident[3:0]: receiver error 4'b0110, received data 4'b0100 or idle timeout 4'b1100, transmit empty 4'b0010, modem change 4'b0000, none 4'b0001.
- R3: When received data and idle timeout are both enabled and pending, the received-data code 4'b0100 is reported.
- R4: A cause whose enable bit is 0 is left out of arbitration in the same cycle. A held cause shows again as soon as its enable returns to 1.
- R5: A receiver error event makes the error cause pending, and a line-status read clears it.
- R6: An idle timeout event makes the timeout cause pending, and a receive-buffer read clears it.
- R7: A modem change event makes the modem cause pending, and a modem-status read clears it.
- R8: The transmit-empty cause becomes pending on a rising edge of tx_empty, or on a rising edge of ie_tx_empty while tx_empty is 1.
- R9: A read of the identification value while it reports 4'b0010 clears the transmit-empty cause, so the next value is 4'b0001. A read while a different cause is reported leaves it pending.
- R10: A write to the transmit holding stage clears the transmit-empty cause, and the write wins over an arming event in the same cycle.
- R11: ident[7:6] are both 1 when fifo_on is 1, and both 0 otherwise. ident[5] is fifo_on AND fifo_deep, and ident[4] is 0.
- R12: irq is the inverse of ident[0].
- R13: For the error, timeout and modem causes, an event in the same cycle as the acknowledging read leaves the cause pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ie_rx_status | input | 1 | Enable for receiver error cause |
| ie_rx_data | input | 1 | Enable for received data and idle timeout causes |
| ie_tx_empty | input | 1 | Enable for transmit-empty cause |
| ie_modem | input | 1 | Enable for modem change cause |
| rx_err_evt | input | 1 | One-cycle receiver error or break event |
| rx_ready | input | 1 | Level: received data at trigger level |
| rx_idle_evt | input | 1 | One-cycle receiver idle timeout event |
| tx_empty | input | 1 | Level: transmit holding stage empty |
| modem_evt | input | 1 | One-cycle modem input change event |
| rd_ident | input | 1 | Read strobe of the identification value |
| rd_line | input | 1 | Read strobe of the line-status register |
| rd_rxbuf | input | 1 | Read strobe of the receive buffer |
| rd_modem | input | 1 | Read strobe of the modem-status register |
| wr_txhold | input | 1 | Write strobe of the transmit holding stage |
| fifo_on | input | 1 | FIFO mode active |
| fifo_deep | input | 1 | Deep-FIFO mode selected |
| ident | output | 8 | Identification value |
| irq | output | 1 | Interrupt request, active high |

## Verification
On every cycle, the assertions check four things. Each held cause reacts correctly to its event and its read, with the event winning. The transmit-empty machine arms and disarms on the right strobes. An enabled receiver error always wins arbitration, and the interrupt line follows the enabled pending causes. The full priority order is shown only by the bench, which sweeps every combination of enables, pending causes and mode bits. The bench scenarios also cover the clearing side effect of the identification read, which depends on which cause is reported at that moment, and the re-arm on a rising enable.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        ID_MODEM  = 4'b0000,
        ID_NONE   = 4'b0001,
        ID_TXEMPTY = 4'b0010,
        ID_RXDATA = 4'b0100,
        ID_RXERR  = 4'b0110,
        ID_RXIDLE = 4'b1100
    } irq_id_e;

    typedef enum logic {
        ST_CLEAR   = 1'b0,
        ST_PENDING = 1'b1
    } pend_state_e;

    localparam int EVT_RXERR  = 0;
    localparam int EVT_RXIDLE = 1;
    localparam int EVT_MODEM  = 2;
    localparam int NUM_EVT    = 3;
    localparam int IDENT_W    = 8;

endpackage

// File: rtl/uart_irq_evt_latch.sv
module uart_irq_evt_latch
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic ack_rd,
    output logic pending
);

    pend_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:   if (set_evt) state_d = ST_PENDING;
            ST_PENDING: if (ack_rd && !set_evt) state_d = ST_CLEAR;
            default:    state_d = ST_CLEAR;
        endcase
    end

    always_comb pending = (state_q == ST_PENDING);

    // R13: a new event wins over the acknowledging read
    p_event_sets_r13: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> pending);
    // R5, R6, R7: the acknowledging read clears the held cause
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !set_evt) |=> !pending);

endmodule

// File: rtl/uart_irq_tx_fsm.sv
module uart_irq_tx_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic enable,
    input  logic wr_hold,
    input  logic rd_ident,
    input  logic shown,
    output logic pending
);

    pend_state_e state_q, state_d;
    logic        empty_q;
    logic        en_q;
    logic        arm;

    always_comb arm = tx_empty && (!empty_q || (enable && !en_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            empty_q <= 1'b1;
            en_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            empty_q <= tx_empty;
            en_q    <= enable;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (arm && !wr_hold) state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (wr_hold)                       state_d = ST_CLEAR;
                else if (rd_ident && shown && !arm) state_d = ST_CLEAR;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_comb pending = (state_q == ST_PENDING);

    p_arm_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !wr_hold) |=> pending);
    p_write_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hold |=> !pending);
    p_ident_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ident && shown && !arm) |=> !pending);

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
(
    input  logic    en_err,
    input  logic    en_rx,
    input  logic    en_tx,
    input  logic    en_modem,
    input  logic    err_p,
    input  logic    data_lvl,
    input  logic    idle_p,
    input  logic    tx_p,
    input  logic    modem_p,
    output irq_id_e code,
    output logic    tx_shown
);

    always_comb begin
        if (en_err && err_p)          code = ID_RXERR;
        else if (en_rx && data_lvl)   code = ID_RXDATA;
        else if (en_rx && idle_p)     code = ID_RXIDLE;
        else if (en_tx && tx_p)       code = ID_TXEMPTY;
        else if (en_modem && modem_p) code = ID_MODEM;
        else                          code = ID_NONE;
    end

    always_comb tx_shown = (code == ID_TXEMPTY);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ie_rx_status,
    input  logic                ie_rx_data,
    input  logic                ie_tx_empty,
    input  logic                ie_modem,
    input  logic                rx_err_evt,
    input  logic                rx_ready,
    input  logic                rx_idle_evt,
    input  logic                tx_empty,
    input  logic                modem_evt,
    input  logic                rd_ident,
    input  logic                rd_line,
    input  logic                rd_rxbuf,
    input  logic                rd_modem,
    input  logic                wr_txhold,
    input  logic                fifo_on,
    input  logic                fifo_deep,
    output logic [IDENT_W-1:0]  ident,
    output logic                irq
);

    logic [NUM_EVT-1:0] evt_set;
    logic [NUM_EVT-1:0] evt_ack;
    logic [NUM_EVT-1:0] evt_pend;
    logic               tx_pend;
    logic               tx_shown;
    irq_id_e            code;

    always_comb begin
        evt_set[EVT_RXERR]  = rx_err_evt;
        evt_set[EVT_RXIDLE] = rx_idle_evt;
        evt_set[EVT_MODEM]  = modem_evt;
        evt_ack[EVT_RXERR]  = rd_line;
        evt_ack[EVT_RXIDLE] = rd_rxbuf;
        evt_ack[EVT_MODEM]  = rd_modem;
    end

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        uart_irq_evt_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (evt_set[g]),
            .ack_rd  (evt_ack[g]),
            .pending (evt_pend[g])
        );
    end

    uart_irq_tx_fsm u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_empty (tx_empty),
        .enable   (ie_tx_empty),
        .wr_hold  (wr_txhold),
        .rd_ident (rd_ident),
        .shown    (tx_shown),
        .pending  (tx_pend)
    );

    uart_irq_arbiter u_arb (
        .en_err   (ie_rx_status),
        .en_rx    (ie_rx_data),
        .en_tx    (ie_tx_empty),
        .en_modem (ie_modem),
        .err_p    (evt_pend[EVT_RXERR]),
        .data_lvl (rx_ready),
        .idle_p   (evt_pend[EVT_RXIDLE]),
        .tx_p     (tx_pend),
        .modem_p  (evt_pend[EVT_MODEM]),
        .code     (code),
        .tx_shown (tx_shown)
    );

    always_comb begin
        ident = {fifo_on, fifo_on, fifo_on & fifo_deep, 1'b0, code};
        irq   = ~code[0];
    end

    p_err_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_rx_status && evt_pend[EVT_RXERR]) |-> (ident[3:0] == 4'b0110));
    p_irq_tracks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((ie_rx_status && evt_pend[EVT_RXERR]) || (ie_rx_data && (rx_ready || evt_pend[EVT_RXIDLE]))
                || (ie_tx_empty && tx_pend) || (ie_modem && evt_pend[EVT_MODEM])));
    p_no_mode_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> (ident[7:4] == 4'b0000));

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ie_rx_status = 1'b1, ie_rx_data = 1'b1, ie_tx_empty = 1'b1, ie_modem = 1'b1;
    logic rx_err_evt = 1'b0, rx_ready = 1'b0, rx_idle_evt = 1'b0, tx_empty = 1'b1, modem_evt = 1'b0;
    logic rd_ident = 1'b0, rd_line = 1'b0, rd_rxbuf = 1'b0, rd_modem = 1'b0, wr_txhold = 1'b0;
    logic fifo_on = 1'b1, fifo_deep = 1'b0;
    logic [7:0] ident;
    logic irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst_n(rst_n),
        .ie_rx_status(ie_rx_status), .ie_rx_data(ie_rx_data),
        .ie_tx_empty(ie_tx_empty), .ie_modem(ie_modem),
        .rx_err_evt(rx_err_evt), .rx_ready(rx_ready), .rx_idle_evt(rx_idle_evt),
        .tx_empty(tx_empty), .modem_evt(modem_evt),
        .rd_ident(rd_ident), .rd_line(rd_line), .rd_rxbuf(rd_rxbuf), .rd_modem(rd_modem),
        .wr_txhold(wr_txhold), .fifo_on(fifo_on), .fifo_deep(fifo_deep),
        .ident(ident), .irq(irq)
    );

    function automatic logic [7:0] model(input logic [3:0] en, input logic err, input logic dat,
                                         input logic idl, input logic tx, input logic mdm,
                                         input logic fe, input logic deep);
        logic [3:0] c;
        if (en[0] && err)      c = 4'b0110;
        else if (en[1] && dat) c = 4'b0100;
        else if (en[1] && idl) c = 4'b1100;
        else if (en[2] && tx)  c = 4'b0010;
        else if (en[3] && mdm) c = 4'b0000;
        else                   c = 4'b0001;
        return {fe, fe, fe & deep, 1'b0, c};
    endfunction

    task automatic check(input logic [7:0] exp, input string req);
        checks++;
        if (ident !== exp || irq !== ~exp[0]) begin
            failures++;
            $display("FAIL %s actual ident=%02h irq=%0b expected ident=%02h irq=%0b",
                     req, ident, irq, exp, ~exp[0]);
        end
    endtask

    // mask bits: 6 err evt, 5 idle evt, 4 modem evt, 3 rd_ident, 2 rd_line, 1 rd_rxbuf, 0 rd_modem
    task automatic strobe(input logic [6:0] m);
        {rx_err_evt, rx_idle_evt, modem_evt, rd_ident, rd_line, rd_rxbuf, rd_modem} = m;
        @(negedge clk);
        {rx_err_evt, rx_idle_evt, modem_evt, rd_ident, rd_line, rd_rxbuf, rd_modem} = '0;
    endtask

    task automatic arm_tx(input logic with_write);
        tx_empty = 1'b0;
        @(negedge clk);
        tx_empty = 1'b1;
        wr_txhold = with_write;
        @(negedge clk);
        wr_txhold = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check(8'hC1, "R1 reset");

        // R2 R3 R4 R11 R12: sweep enables, pending causes and mode bits
        for (int idx = 0; idx < 1024; idx++) begin
            {ie_modem, ie_tx_empty, ie_rx_data, ie_rx_status} = idx[3:0];
            fifo_deep = idx[4];
            fifo_on = idx[9];
            rx_ready = 1'b0;
            tx_empty = 1'b1;
            do_reset();
            rx_err_evt = idx[4];
            rx_idle_evt = idx[6];
            modem_evt = idx[8];
            tx_empty = !idx[7];
            @(negedge clk);
            {rx_err_evt, rx_idle_evt, modem_evt} = '0;
            tx_empty = 1'b1;
            @(negedge clk);
            rx_ready = idx[5];
            #1;
            check(model(idx[3:0], idx[4], idx[5], idx[6], idx[7], idx[8], idx[9], idx[4]), "R2 sweep");
        end

        {ie_modem, ie_tx_empty, ie_rx_data, ie_rx_status} = 4'hF;
        fifo_on = 1'b1; fifo_deep = 1'b0; rx_ready = 1'b0; tx_empty = 1'b1;
        do_reset();
        check(8'hC1, "R1 reset after sweep");

        strobe(7'b1000000); check(8'hC6, "R5 error set");
        strobe(7'b0000100); check(8'hC1, "R5 line read clears");

        strobe(7'b0100000); check(8'hCC, "R6 timeout set");
        rx_ready = 1'b1; #1; check(8'hC4, "R3 data over timeout");
        rx_ready = 1'b0;
        strobe(7'b0000010); check(8'hC1, "R6 buffer read clears");

        strobe(7'b0010000); check(8'hC0, "R7 modem set");
        strobe(7'b0000001); check(8'hC1, "R7 modem read clears");

        arm_tx(1'b0); check(8'hC2, "R8 empty edge arms");
        strobe(7'b0001000); check(8'hC1, "R9 ident read clears");

        arm_tx(1'b0);
        strobe(7'b1000000);
        strobe(7'b0001000); check(8'hC6, "R9 read while error shown");
        strobe(7'b0000100); check(8'hC2, "R9 tx cause kept");

        strobe(7'b0001000);
        ie_tx_empty = 1'b0; @(negedge clk);
        check(8'hC1, "R4 tx disabled");
        ie_tx_empty = 1'b1; @(negedge clk);
        check(8'hC2, "R8 enable rise arms");
        wr_txhold = 1'b1; @(negedge clk); wr_txhold = 1'b0;
        check(8'hC1, "R10 write clears");
        arm_tx(1'b1); check(8'hC1, "R10 write wins over arm");

        strobe(7'b1000100); check(8'hC6, "R13 event wins over read");
        ie_rx_status = 1'b0; #1; check(8'hC1, "R4 error disabled");
        ie_rx_status = 1'b1; #1; check(8'hC6, "R4 error re-enabled");
        strobe(7'b0000100); check(8'hC1, "R5 cleared");

        fifo_on = 1'b0; #1; check(8'h01, "R11 fifo off");
        fifo_deep = 1'b1; #1; check(8'h01, "R11 deep ignored when off");
        fifo_on = 1'b1; #1; check(8'hE1, "R11 deep mode");
        strobe(7'b0010000); check(8'hE0, "R12 modem irq");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule